// File: doc/BRIEF.md
# Pad Interception Scan Chain

This block sits between the core-side signals of a group of pins and the wires that run to their IO pads. Each pin is declared at elaboration as one of four kinds: input only, output only, output with a tristate enable, or bidirectional with a direction enable. Each kind gets only the scan cells it needs, one for every wire it uses. In normal operation every tapped wire goes straight through a two-way multiplexer, so the core and the pad are joined and the scan logic has no effect.

In scan mode the multiplexers switch over. The pad side is then driven from one set of hold bits, and the core side reads from a different set. Test logic can therefore drive a pad while it watches what the core produces, or sample a pad while it feeds the core a chosen level. A fault can then be placed either in the pad or in the peripheral. Three strobes control the chain, all sampled on the test clock: capture, shift and update. The shift path has a serial input and a serial output.

Top module: `bscan_pad_chain`

## Requirements
- R1: The pin kind is a 2-bit field per pin in `PIN_KINDS` (pin p at bits 2p+1:2p): 0 input, 1 output, 2 tristate output, 3 bidirectional. A pin takes 2, 2, 4 or 6 chain positions. Pin 0 holds the lowest positions and each pin follows the one before it. Within a pin the order is: input `pad_in` sample, `core_in` drive. Output: `core_out` sample, `pad_out` drive. Tristate: `core_out` sample, `core_oe` sample, `pad_out` drive, `pad_oe` drive. Bidirectional: `core_out` sample, `core_oe` sample, `pad_in` sample, `pad_out` drive, `pad_oe` drive, `core_in` drive.
- R2: In normal mode, `pad_out` follows `core_out` for every kind except input. `pad_oe` follows `core_oe` for tristate and bidirectional pins and is 1 for output pins. `core_in` follows `pad_in` for input and bidirectional pins.
- R3: Wires a kind does not use are held constant in both modes: an input pin drives `pad_out` and `pad_oe` at 0, and output and tristate pins drive `core_in` at 0.
- R4: `scan_mode` is registered. Interception starts at the first rising edge on which `scan_mode` is sampled high, and pass-through returns at the first edge on which it is sampled low.
- R5: Capture loads every sample position from its live signal and loads every drive position with its own current hold value.
- R6: Shift moves the chain one position per clock toward position 0. `scan_in` enters the highest position, and `scan_out` always shows position 0.
- R7: Update copies the shift stage into the hold stage. Without update the hold stage and all scan-mode outputs stay unchanged, including while shifting.
- R8: In scan mode `pad_out` and `pad_oe` come from the pin's pad drive positions of the hold stage, and `core_in` comes from its separate core drive position.
- R9: A captured core output does not depend on the level at any pad, and a captured pad input does not depend on any core signal.
- R10: Capture takes priority over shift when both are high. Reset clears the shift stage, the hold stage and the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_mode | input | 1 | Request for interception mode |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial data into the chain |
| scan_out | output | 1 | Serial data from chain position 0 |
| core_out | input | NUM_PINS | Output levels from the core |
| core_oe | input | NUM_PINS | Output enables from the core |
| core_in | output | NUM_PINS | Input levels delivered to the core |
| pad_out | output | NUM_PINS | Output levels to the pads |
| pad_oe | output | NUM_PINS | Output enables to the pads |
| pad_in | input | NUM_PINS | Input levels from the pads |

## Verification
A wrong multiplexer select or a wrong chain offset shows at the pad or core pins on the first edge after the mode register changes. The bench compares every pin kind against levels it works out itself. A wrong capture source or a wrong shift direction shows at `scan_out` within one chain length of shifting, because the bench unloads the whole chain and compares each bit with a vector it builds from the live signals. A hold stage that leaks during shifting changes the scan-mode outputs in the middle of the shift, and the bench samples those outputs on every shift cycle.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    PIN_IN    = 2'd0,
    PIN_OUT   = 2'd1,
    PIN_TRI   = 2'd2,
    PIN_BIDIR = 2'd3
  } pin_kind_e;

  // chain positions used by one pin of the given kind
  function automatic int kind_bits(input logic [1:0] kind);
    case (kind)
      2'd0:    return 2;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/bscan_tap_mux.sv
module bscan_tap_mux (
  input  logic sel,
  input  logic thru,
  input  logic test,
  output logic y
);
  assign y = sel ? test : thru;
endmodule

// File: rtl/bscan_chain_reg.sv
module bscan_chain_reg #(
  parameter int LEN = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           shift_en,
  input  logic           upd_en,
  input  logic           scan_in,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] chain_q,
  output logic [LEN-1:0] hold_q,
  output logic           scan_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (cap_en) begin
      chain_q <= cap_vec;
    end else if (shift_en) begin
      chain_q <= {scan_in, chain_q[LEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (upd_en) begin
      hold_q <= chain_q;
    end
  end

  assign scan_out = chain_q[0];

endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain
  import bscan_pkg::*;
#(
  parameter int                  NUM_PINS  = 4,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 8'b11_10_01_00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_mode,
  input  logic                cap_en,
  input  logic                shift_en,
  input  logic                upd_en,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] core_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] pad_in
);

  // first chain position of pin p (p == NUM_PINS gives the chain length)
  function automatic int pin_base(input int p);
    int acc;
    acc = 0;
    for (int q = 0; q < p; q++) acc += kind_bits(PIN_KINDS[2*q +: 2]);
    return acc;
  endfunction

  localparam int CHAIN_LEN = pin_base(NUM_PINS);

  logic                 intercept;
  logic [CHAIN_LEN-1:0] cap_vec;
  logic [CHAIN_LEN-1:0] chain_q;
  logic [CHAIN_LEN-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intercept <= 1'b0;
    else        intercept <= scan_mode;
  end

  bscan_chain_reg #(.LEN(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .upd_en   (upd_en),
    .scan_in  (scan_in),
    .cap_vec  (cap_vec),
    .chain_q  (chain_q),
    .hold_q   (hold_q),
    .scan_out (scan_out)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [1:0] KIND = PIN_KINDS[2*p +: 2];
    localparam int         B    = pin_base(p);

    if (KIND == PIN_IN) begin : g_in
      assign cap_vec[B]   = pad_in[p];
      assign cap_vec[B+1] = hold_q[B+1];
      assign pad_out[p]   = 1'b0;
      assign pad_oe[p]    = 1'b0;
      bscan_tap_mux u_ci (.sel(intercept), .thru(pad_in[p]), .test(hold_q[B+1]), .y(core_in[p]));
    end else if (KIND == PIN_OUT) begin : g_out
      assign cap_vec[B]   = core_out[p];
      assign cap_vec[B+1] = hold_q[B+1];
      assign pad_oe[p]    = 1'b1;
      assign core_in[p]   = 1'b0;
      bscan_tap_mux u_po (.sel(intercept), .thru(core_out[p]), .test(hold_q[B+1]), .y(pad_out[p]));
    end else if (KIND == PIN_TRI) begin : g_tri
      assign cap_vec[B]   = core_out[p];
      assign cap_vec[B+1] = core_oe[p];
      assign cap_vec[B+2] = hold_q[B+2];
      assign cap_vec[B+3] = hold_q[B+3];
      assign core_in[p]   = 1'b0;
      bscan_tap_mux u_po (.sel(intercept), .thru(core_out[p]), .test(hold_q[B+2]), .y(pad_out[p]));
      bscan_tap_mux u_pe (.sel(intercept), .thru(core_oe[p]),  .test(hold_q[B+3]), .y(pad_oe[p]));
    end else begin : g_bidir
      assign cap_vec[B]   = core_out[p];
      assign cap_vec[B+1] = core_oe[p];
      assign cap_vec[B+2] = pad_in[p];
      assign cap_vec[B+3] = hold_q[B+3];
      assign cap_vec[B+4] = hold_q[B+4];
      assign cap_vec[B+5] = hold_q[B+5];
      bscan_tap_mux u_po (.sel(intercept), .thru(core_out[p]), .test(hold_q[B+3]), .y(pad_out[p]));
      bscan_tap_mux u_pe (.sel(intercept), .thru(core_oe[p]),  .test(hold_q[B+4]), .y(pad_oe[p]));
      bscan_tap_mux u_ci (.sel(intercept), .thru(pad_in[p]),   .test(hold_q[B+5]), .y(core_in[p]));
    end
  end

endmodule

// File: rtl/bscan_pad_chain_chk.sv
module bscan_pad_chain_chk
  import bscan_pkg::*;
#(
  parameter int                    NUM_PINS  = 4,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 8'b11_10_01_00,
  parameter int                    CHAIN_LEN = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scan_mode,
  input logic                 shift_en,
  input logic                 cap_en,
  input logic                 upd_en,
  input logic                 scan_in,
  input logic                 intercept,
  input logic [CHAIN_LEN-1:0] chain_q,
  input logic [CHAIN_LEN-1:0] hold_q,
  input logic [NUM_PINS-1:0]  core_out,
  input logic [NUM_PINS-1:0]  core_oe,
  input logic [NUM_PINS-1:0]  pad_in,
  input logic [NUM_PINS-1:0]  pad_out,
  input logic [NUM_PINS-1:0]  pad_oe,
  input logic [NUM_PINS-1:0]  core_in
);

  AST_MODE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |=> intercept); // R4
  AST_MODE_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_mode |=> !intercept); // R4
  AST_SHIFT_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> chain_q[CHAIN_LEN-1] == $past(scan_in)); // R6
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(hold_q)); // R7
  AST_NORMAL_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    (!intercept && $stable(intercept) && $stable(core_out) && $stable(core_oe) && $stable(pad_in))
      |-> ($stable(pad_out) && $stable(pad_oe) && $stable(core_in))); // R2

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [1:0] KIND = PIN_KINDS[2*p +: 2];
    if (KIND == PIN_IN) begin : g_quiet_pad
      AST_IN_PAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out[p] == 1'b0) && (pad_oe[p] == 1'b0)); // R3
    end else begin : g_out_pass
      AST_OUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !intercept |-> pad_out[p] == core_out[p]); // R2
    end
    if (KIND == PIN_IN || KIND == PIN_BIDIR) begin : g_in_pass
      AST_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !intercept |-> core_in[p] == pad_in[p]); // R2
    end else begin : g_quiet_core
      AST_CORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        core_in[p] == 1'b0); // R3
    end
  end

endmodule

bind bscan_pad_chain bscan_pad_chain_chk #(
  .NUM_PINS  (NUM_PINS),
  .PIN_KINDS (PIN_KINDS),
  .CHAIN_LEN (CHAIN_LEN)
) u_chk (.*);

// File: tb/bscan_pad_chain_tb.sv
module bscan_pad_chain_tb;

  localparam int NP = 4;
  localparam int L  = 14;   // 2 + 2 + 4 + 6 for kinds input, output, tristate, bidir

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_mode = 1'b0, cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, scan_in = 1'b0;
  logic scan_out;
  logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [NP-1:0] core_in, pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bscan_pad_chain #(.NUM_PINS(NP), .PIN_KINDS(8'b11_10_01_00)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin 0 input, pin 1 output, pin 2 tristate, pin 3 bidirectional
  function automatic logic [11:0] exp_norm(input logic [3:0] co, input logic [3:0] coe,
                                           input logic [3:0] pi);
    logic [3:0] po, poe, ci;
    po  = {co[3], co[2], co[1], 1'b0};
    poe = {coe[3], coe[2], 1'b1, 1'b0};
    ci  = {pi[3], 1'b0, 1'b0, pi[0]};
    return {po, poe, ci};
  endfunction

  function automatic logic [11:0] exp_scan(input logic [L-1:0] h);
    logic [3:0] po, poe, ci;
    po  = {h[11], h[6], h[3], 1'b0};
    poe = {h[12], h[7], 1'b1, 1'b0};
    ci  = {h[13], 1'b0, 1'b0, h[1]};
    return {po, poe, ci};
  endfunction

  function automatic logic [L-1:0] exp_cap(input logic [3:0] co, input logic [3:0] coe,
                                           input logic [3:0] pi, input logic [L-1:0] h);
    logic [L-1:0] c;
    c = h;
    c[0] = pi[0];
    c[2] = co[1];
    c[4] = co[2];  c[5] = coe[2];
    c[8] = co[3];  c[9] = coe[3]; c[10] = pi[3];
    return c;
  endfunction

  function automatic logic [11:0] outs();
    return {pad_out, pad_oe, core_in};
  endfunction

  // shift the whole chain: feed v (bit 0 first), collect what leaves scan_out,
  // and check the scan-mode outputs stay put on every shift cycle
  task automatic run_shift(input logic [L-1:0] v, input logic [11:0] steady,
                           output logic [L-1:0] got);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      got[i] = scan_out;
      if (i > 0) chk("R7 outputs during shift", 64'(outs()), 64'(steady));
      scan_in = v[i];
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap_en = 1'b1;
    @(negedge clk); cap_en = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_en = 1'b1;
    @(negedge clk); upd_en = 1'b0;
  endtask

  task automatic t_reset();
    core_out = 4'b1110; core_oe = 4'b1100; pad_in = 4'b1001;
    #1;
    chk("R10 reset scan_out", 64'(scan_out), 64'd0);
    chk("R2 pass-through in reset", 64'(outs()), 64'(exp_norm(4'b1110, 4'b1100, 4'b1001)));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_normal();
    logic [3:0] pats [4] = '{4'h0, 4'hF, 4'hA, 4'h5};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      core_out = pats[i]; core_oe = ~pats[(i + 1) % 4]; pad_in = pats[(i + 2) % 4];
      #1;
      chk("R2 normal pass", 64'(outs()), 64'(exp_norm(core_out, core_oe, pad_in)));
      chk("R3 untapped quiet", 64'({pad_out[0], pad_oe[0], core_in[2:1]}), 64'd0);
    end
  endtask

  task automatic t_enter();
    @(negedge clk);
    scan_mode = 1'b1;
    core_out = 4'hF; core_oe = 4'hF; pad_in = 4'hF;
    #1;
    chk("R4 not yet intercepting", 64'(outs()), 64'(exp_norm(4'hF, 4'hF, 4'hF)));
    @(negedge clk);
    chk("R4 intercept, zero hold", 64'(outs()), 64'(exp_scan('0)));
  endtask

  task automatic t_load(input logic [L-1:0] v, input logic [L-1:0] old_hold);
    logic [L-1:0] got;
    run_shift(v, exp_scan(old_hold), got);
    chk("R7 no update yet", 64'(outs()), 64'(exp_scan(old_hold)));
    pulse_upd();
    chk("R8 pad and core driven from hold", 64'(outs()), 64'(exp_scan(v)));
  endtask

  task automatic t_capture(input logic [3:0] co, input logic [3:0] coe, input logic [3:0] pi,
                           input logic [L-1:0] h, input string tag);
    logic [L-1:0] got;
    @(negedge clk);
    core_out = co; core_oe = coe; pad_in = pi;
    pulse_cap();
    run_shift('0, exp_scan(h), got);
    chk(tag, 64'(got), 64'(exp_cap(co, coe, pi, h)));
  endtask

  task automatic t_priority(input logic [L-1:0] h);
    logic [L-1:0] got;
    @(negedge clk);
    core_out = 4'b0110; core_oe = 4'b1001; pad_in = 4'b1000;
    cap_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1;
    @(negedge clk);
    cap_en = 1'b0; shift_en = 1'b0;
    run_shift('0, exp_scan(h), got);
    chk("R10 capture over shift", 64'(got), 64'(exp_cap(4'b0110, 4'b1001, 4'b1000, h)));
  endtask

  task automatic t_leave(input logic [L-1:0] h);
    @(negedge clk);
    scan_mode = 1'b0;
    core_out = 4'b0011; core_oe = 4'b0101; pad_in = 4'b0110;
    #1;
    chk("R4 still intercepting", 64'(outs()), 64'(exp_scan(h)));
    @(negedge clk);
    chk("R4 back to pass-through", 64'(outs()), 64'(exp_norm(4'b0011, 4'b0101, 4'b0110)));
  endtask

  initial begin
    logic [L-1:0] v1, v2;
    v1 = 14'b10_1101_0110_1011;
    v2 = 14'b01_0010_1001_0100;
    t_reset();
    t_normal();
    t_enter();
    t_load(v1, '0);                                   // R6 R7 R8
    t_capture(4'b1010, 4'b0110, 4'b0101, v1, "R5 capture pattern A");
    t_capture(4'b0101, 4'b1001, 4'b1010, v1, "R9 capture with pad opposite core");
    t_load(v2, v1);
    t_capture(4'b1111, 4'b0000, 4'b0000, v2, "R1 chain layout");
    t_priority(v2);
    t_leave(v2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule